// File: doc/BRIEF.md
# Coincident-Selection Core Word Memory Controller

This block models a word-organised ferrite-core store made of one bit plane per data bit. Each plane is a grid of bistable cells. A cell changes state only where an energised row line and an energised column line cross. The controller takes a word request, decodes the address into one row line and one column line, and drives that same pair on every plane at once. A write is done in two steps. The first step forces the word to zero. The second step sets the cells whose new bit is one. In that step a plane that must hold zero gets no drive.

A read drives the selected cells toward zero and watches each plane's sense output. A plane pulses its sense output only if its cell held a one. The read empties the word, so the controller writes the sensed value back in a further step. Read data is presented as soon as sensing is done, and the controller stays busy until the write-back completes. A request can also ask for a read with no write-back, which leaves the word cleared. The drive and sense lines are brought out to the ports so that the core drive activity can be observed.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a sequence, and that is the only back-pressure. The requester must hold its request stable until it is taken. Read results leave as a single-cycle `rd_valid` pulse with no back-pressure, so the consumer must capture `rd_data` in that cycle.

Top module: `ccmem_ctrl`

## Requirements
- R1: A request is accepted only on a clock edge with `req_valid` and `req_ready` both high. From the next cycle `busy` is high and `req_ready` is low until the sequence ends. A write sequence and a read with write-back each keep `busy` high for exactly two cycles. A read without write-back keeps it high for one cycle.
- R2: In every cycle, either no row or column line is energised, or exactly one row line and exactly one column line are energised together.
- R3: During a sequence, the energised row line has index `req_addr[2:0]` and the energised column line has index `req_addr[5:3]`. Both are taken from the accepted request.
- R4: A write first drives a clear step: `drv_set`=0 with all bits of `plane_drive` set. In the next cycle it drives a set step: `drv_set`=1 with `plane_drive` equal to the write data. Afterwards the word holds exactly the write data, whatever it held before.
- R5: A read drives a clear step on all planes. During that cycle, `sense` bit p equals the stored bit p. In the next cycle `rd_valid` is high for one cycle, and `rd_data` equals the stored word.
- R6: A read with write-back follows its sense cycle with a set step whose `plane_drive` equals the sensed word. Later reads of that address return the same word.
- R7: A read with `req_keep_clear`=1 performs no set step. `busy` is low in the cycle where `rd_valid` is high, and the word reads as zero afterwards. `req_keep_clear` has no effect on writes.
- R8: An access to one address leaves every other address unchanged.
- R9: After reset, `busy`, `rd_valid`, all row and column lines and `sense` are low, `req_ready` is high, and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_keep_clear | input | 1 | On a read, skip the write-back |
| req_addr | input | ADDR_W (6) | Word address: low half selects the row, high half the column |
| req_wdata | input | DATA_W (8) | Write data |
| rd_valid | output | 1 | Single-cycle read result strobe |
| rd_data | output | DATA_W (8) | Read result |
| busy | output | 1 | Sequence in progress |
| x_line | output | 2**X_BITS (8) | Row select lines |
| y_line | output | 2**(ADDR_W-X_BITS) (8) | Column select lines |
| drv_set | output | 1 | Drive polarity: 1 sets, 0 clears |
| plane_drive | output | DATA_W (8) | Per-plane drive enable (0 = inhibited) |
| sense | output | DATA_W (8) | Per-plane sense pulses |

## Verification
The hardest case to reach is a word that is read repeatedly and rewritten between reads. Only that shows a missing write-back, a clear step that leaves a stale one behind, or a read without write-back that fails to empty the word. Random stimulus therefore sends most requests to a small pool of eight addresses, so words are revisited many times under mixed read, write and read-without-write-back commands. Directed sequences add an all-ones word overwritten by zero and by a sparse pattern, a double read, a read that empties the word, and a final sweep of every address against the bench model to expose disturbance of words that were never addressed.

// File: rtl/ccmem_pkg.sv
package ccmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_SET   = 2'd2
  } ccmem_state_e;
endpackage

// File: rtl/ccmem_line_dec.sv
module ccmem_line_dec #(
  parameter int SEL_W = 3,
  localparam int LINES = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] idx,
  output logic [LINES-1:0] line
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign line[k] = en && (idx == SEL_W'(k));
  end
endmodule

// File: rtl/ccmem_plane.sv
module ccmem_plane #(
  parameter int XN = 8,
  parameter int YN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XN-1:0] x_line,
  input  logic [YN-1:0] y_line,
  input  logic          en,
  input  logic          set_pol,
  output logic          sense
);
  logic [XN*YN-1:0] cells;
  logic             hit;

  // A cell flips only where both its row and column lines are energised.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (en) begin
      for (int i = 0; i < XN; i++) begin
        for (int j = 0; j < YN; j++) begin
          if (x_line[i] && y_line[j]) cells[i*YN+j] <= set_pol;
        end
      end
    end
  end

  // The sense line threads every cell; only a 1-to-0 flip produces a pulse.
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < XN; i++) begin
      for (int j = 0; j < YN; j++) begin
        hit = hit | (x_line[i] & y_line[j] & cells[i*YN+j]);
      end
    end
    sense = en & ~set_pol & hit;
  end
endmodule

// File: rtl/ccmem_seq.sv
module ccmem_seq
  import ccmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_keep_clear,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] sense_vec,
  output logic              req_ready,
  output logic              busy,
  output logic              drv_act,
  output logic              drv_set,
  output logic [DATA_W-1:0] plane_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  ccmem_state_e      state;
  logic [DATA_W-1:0] word_q;
  logic              is_read_q;
  logic              keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      word_q    <= '0;
      is_read_q <= 1'b0;
      keep_q    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            word_q    <= req_wdata;
            is_read_q <= !req_write;
            keep_q    <= req_keep_clear && !req_write;
            state     <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          if (is_read_q) begin
            word_q   <= sense_vec;
            rd_data  <= sense_vec;
            rd_valid <= 1'b1;
            state    <= keep_q ? ST_IDLE : ST_SET;
          end else begin
            state <= ST_SET;
          end
        end
        ST_SET:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    req_ready = !busy;
    drv_act   = busy;
    drv_set   = (state == ST_SET);
    case (state)
      ST_CLEAR: plane_en = '1;
      ST_SET:   plane_en = word_q;
      default:  plane_en = '0;
    endcase
  end
endmodule

// File: rtl/ccmem_ctrl.sv
module ccmem_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int X_BITS = 3,
  localparam int Y_BITS = ADDR_W - X_BITS,
  localparam int XN = 1 << X_BITS,
  localparam int YN = 1 << Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_keep_clear,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [XN-1:0]     x_line,
  output logic [YN-1:0]     y_line,
  output logic              drv_set,
  output logic [DATA_W-1:0] plane_drive,
  output logic [DATA_W-1:0] sense
);
  logic              drv_act;
  logic [ADDR_W-1:0] cur_addr;

  ccmem_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_keep_clear(req_keep_clear), .req_addr(req_addr), .req_wdata(req_wdata),
    .sense_vec(sense), .req_ready(req_ready), .busy(busy), .drv_act(drv_act),
    .drv_set(drv_set), .plane_en(plane_drive), .cur_addr(cur_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  ccmem_line_dec #(.SEL_W(X_BITS)) xdec_i (
    .en(drv_act), .idx(cur_addr[X_BITS-1:0]), .line(x_line)
  );

  ccmem_line_dec #(.SEL_W(Y_BITS)) ydec_i (
    .en(drv_act), .idx(cur_addr[ADDR_W-1:X_BITS]), .line(y_line)
  );

  for (genvar p = 0; p < DATA_W; p++) begin : g_plane
    ccmem_plane #(.XN(XN), .YN(YN)) plane_i (
      .clk(clk), .rst_n(rst_n), .x_line(x_line), .y_line(y_line),
      .en(plane_drive[p]), .set_pol(drv_set), .sense(sense[p])
    );
  end
endmodule

// File: rtl/ccmem_ctrl_chk.sv
module ccmem_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int XN = 8,
  parameter int YN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              busy,
  input logic [XN-1:0]     x_line,
  input logic [YN-1:0]     y_line,
  input logic              drv_set,
  input logic [DATA_W-1:0] plane_drive,
  input logic [DATA_W-1:0] sense
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_no_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_coincident_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_line) && $onehot0(y_line) && ((|x_line) == (|y_line)));

  assert_set_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|x_line) && drv_set) |-> $past((|x_line) && !drv_set));

  assert_read_after_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past((|x_line) && !drv_set && (plane_drive == '1)));

  assert_sense_only_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sense) |-> ((|x_line) && !drv_set));

  assert_restore_same_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|x_line) && drv_set) |-> ($stable(x_line) && $stable(y_line)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!(|x_line) && (plane_drive == '0)));
endmodule

bind ccmem_ctrl ccmem_ctrl_chk #(.DATA_W(DATA_W), .XN(XN), .YN(YN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .busy(busy), .x_line(x_line), .y_line(y_line),
  .drv_set(drv_set), .plane_drive(plane_drive), .sense(sense)
);

// File: tb/ccmem_ctrl_tb_top.sv
module ccmem_ctrl_tb_top;
  localparam int DW = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_keep_clear = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          busy;
  logic [7:0]    x_line;
  logic [7:0]    y_line;
  logic          drv_set;
  logic [DW-1:0] plane_drive;
  logic [DW-1:0] sense;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [64];

  always #10 clk = ~clk;

  ccmem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_keep_clear(req_keep_clear), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .x_line(x_line), .y_line(y_line), .drv_set(drv_set),
    .plane_drive(plane_drive), .sense(sense)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] onehot8(input logic [2:0] idx);
    return 8'b1 << idx;
  endfunction

  task automatic run_op(input bit wr, input bit keep, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string dtag);
    logic [DW-1:0] expd;
    expd = model[a];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_keep_clear = keep;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R1", {30'd0, busy, req_ready}, 32'h2);
    chk($countones(x_line) == 1 && $countones(y_line) == 1, "R2", {16'd0, x_line, y_line}, 32'h0);
    chk(x_line === onehot8(a[2:0]) && y_line === onehot8(a[5:3]), "R3",
        {16'd0, x_line, y_line}, {16'd0, onehot8(a[2:0]), onehot8(a[5:3])});
    chk(drv_set === 1'b0 && plane_drive === 8'hFF, wr ? "R4" : "R5",
        {23'd0, drv_set, plane_drive}, 32'h0FF);
    if (!wr) chk(sense === expd, "R5", {24'd0, sense}, {24'd0, expd});
    @(negedge clk);
    if (wr) begin
      chk(drv_set === 1'b1 && plane_drive === d && busy === 1'b1, "R4",
          {23'd0, drv_set, plane_drive}, {23'd0, 1'b1, d});
      if (keep) chk(busy === 1'b1, "R7", {31'd0, busy}, 32'd1);
      model[a] = d;
    end else begin
      chk(rd_valid === 1'b1 && rd_data === expd, dtag, {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, expd});
      if (keep) begin
        chk(busy === 1'b0 && x_line === 8'h0, "R7", {23'd0, busy, x_line}, 32'h0);
        model[a] = '0;
      end else begin
        chk(drv_set === 1'b1 && plane_drive === expd && busy === 1'b1, "R6",
            {23'd0, drv_set, plane_drive}, {23'd0, 1'b1, expd});
      end
    end
    if (wr || !keep) begin
      @(negedge clk);
      chk(busy === 1'b0 && x_line === 8'h0 && rd_valid === 1'b0, "R1",
          {22'd0, busy, rd_valid, x_line}, 32'h0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd51873);
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: quiet outputs and empty store after reset
    chk(busy === 1'b0 && req_ready === 1'b1 && rd_valid === 1'b0 && x_line === 8'h0 &&
        y_line === 8'h0 && sense === 8'h0, "R9", {29'd0, busy, req_ready, rd_valid}, 32'h2);
    run_op(1'b0, 1'b0, 6'd37, 8'h00, "R9");
    run_op(1'b0, 1'b0, 6'd0, 8'h00, "R9");

    // R4: clear-before-set with stale ones; R7 flag ignored on write
    run_op(1'b1, 1'b0, 6'd63, 8'hFF, "R4");
    run_op(1'b1, 1'b1, 6'd63, 8'h00, "R4");
    run_op(1'b0, 1'b0, 6'd63, 8'h00, "R4");
    run_op(1'b1, 1'b0, 6'd63, 8'hFF, "R4");
    run_op(1'b1, 1'b0, 6'd63, 8'h5A, "R4");
    run_op(1'b0, 1'b0, 6'd63, 8'h00, "R4");
    // R6: double read keeps the word
    run_op(1'b1, 1'b0, 6'd0, 8'hC3, "R6");
    run_op(1'b0, 1'b0, 6'd0, 8'h00, "R6");
    run_op(1'b0, 1'b0, 6'd0, 8'h00, "R6");
    // R7: read without write-back empties the word
    run_op(1'b0, 1'b1, 6'd0, 8'h00, "R7");
    run_op(1'b0, 1'b0, 6'd0, 8'h00, "R7");
    // R8: neighbours sharing a row or column line stay untouched
    run_op(1'b1, 1'b0, 6'd9, 8'hA5, "R8");
    run_op(1'b1, 1'b0, 6'd1, 8'h3C, "R8");
    run_op(1'b1, 1'b0, 6'd8, 8'h81, "R8");
    run_op(1'b0, 1'b0, 6'd9, 8'h00, "R8");

    for (int n = 0; n < 600; n++) begin
      int unsigned kind;
      logic [AW-1:0] a;
      kind = $urandom_range(0, 99);
      a = ($urandom_range(0, 3) != 0) ? AW'($urandom_range(0, 7) * 9) : AW'($urandom_range(0, 63));
      if (kind < 45)      run_op(1'b1, kind[0], a, 8'($urandom), "R5");
      else if (kind < 85) run_op(1'b0, 1'b0, a, 8'h00, "R5");
      else                run_op(1'b0, 1'b1, a, 8'h00, "R7");
    end

    // R8: sweep every word against the model
    for (int k = 0; k < 64; k++) run_op(1'b0, 1'b0, AW'(k), 8'h00, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule